// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment registers (extra, code, stack and data) and turns a segment-relative reference into a 20-bit physical address. A segment's base is its register value with four zero bits appended below it. Every segment therefore starts on a 16-byte boundary and covers the 65,536 bytes above its base. Different segments are free to share memory. A software write port loads any segment register.

An address request supplies a segment select and a 16-bit offset. One clock later the block presents the physical address, which is the base plus the offset wrapped into the 1 MB space, together with the base it used. A separate pair of selects names two segments. One cycle later a flag reports whether their 64 KB windows share any byte, with the comparison taken modulo 2^20.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment register holds FFFFh and the extra, stack and data registers hold 0000h.
- R2: Segment selects use the encoding 00 = extra, 01 = code, 10 = stack, 11 = data, on the write port, the request port and both overlap selects.
- R3: When wr_en is high at a clock edge, wr_data is loaded into the register named by wr_sel. A request in that same cycle still sees the old value, and a request in any later cycle sees the new value.
- R4: rsp_base equals the selected register value shifted left by four bits, so its low four bits are zero.
- R5: rsp_addr equals rsp_base plus the zero-extended offset, truncated to 20 bits, so that a sum above FFFFFh wraps to the bottom of memory.
- R6: rsp_valid is high in exactly the cycle after a cycle with req_valid high. rsp_addr and rsp_base are registered and reflect the request of the previous cycle.
- R7: After a cycle with req_valid low, rsp_addr and rsp_base keep their previous values.
- R8: One cycle after the overlap selects are presented, ovl_flag is high when either base minus the other, taken modulo 2^20, is below 10000h, and is low otherwise.
- R9: ovl_flag is high one cycle after both overlap selects name the same segment.
- R10: While rst_n is low, rsp_valid, rsp_addr, rsp_base and ovl_flag are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Register to write (R2 encoding) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used by the request |
| req_ofs | input | 16 | Offset within the segment |
| ovl_sel_a | input | 2 | First segment of the overlap test |
| ovl_sel_b | input | 2 | Second segment of the overlap test |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_addr | output | 20 | Physical address |
| rsp_base | output | 20 | Base address of the requested segment |
| ovl_flag | output | 1 | The two selected segments share memory |

## Verification
The bench targets the wrap of FFFF0h plus FFFFh to 0FFEFh. A design that carries into a 21st bit, or that saturates, returns the wrong address there. It writes and requests the same register in one cycle: a design that forwards the write shows the new base one cycle too early. It also checks the code register's non-zero reset value, and a swapped select encoding shows up as wrong addresses right after reset. The overlap cases include a pair that only shares memory across the top of the address space and a pair that names the same segment twice, so a comparison that ignores the wrap, or checks only one direction, reports the wrong flag.

// File: rtl/seg_addr_pkg.sv
`timescale 1ns/1ps
package seg_addr_pkg;

    // Number of simultaneously active segments
    localparam int NUM_SEGS = 4;
    localparam int SEL_W    = $clog2(NUM_SEGS);

    // Select encoding shared by every port that names a segment
    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_sel_e;

endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile #(
    parameter int NSEG     = 4,
    parameter int SEG_W    = 16,
    parameter int CODE_IDX = 1,
    parameter logic [SEG_W-1:0] CODE_RST = '1,
    localparam int SEL_W   = $clog2(NSEG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [SEG_W-1:0]            wr_data,
    output logic [NSEG-1:0][SEG_W-1:0]  segs
);

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
    } rf_t;

    rf_t st_d, st_q;

    // Next-state: a write lands in the selected slot only
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.seg[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                st_q.seg[i] <= (i == CODE_IDX) ? CODE_RST : '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign segs = st_q.seg;

endmodule

// File: rtl/seg_addr_calc.sv
`timescale 1ns/1ps
module seg_addr_calc #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  base,
    output logic [PA_W-1:0]  addr
);

    localparam int EXT_W = PA_W - OFS_W;

    logic [PA_W-1:0] ofs_ext;

    always_comb begin
        base    = {seg, {SHIFT{1'b0}}};
        ofs_ext = {{EXT_W{1'b0}}, ofs};
        // Carry out of the top bit is dropped: addresses wrap
        addr    = base + ofs_ext;
    end

endmodule

// File: rtl/seg_overlap_cmp.sv
`timescale 1ns/1ps
module seg_overlap_cmp #(
    parameter int PA_W  = 20,
    parameter int OFS_W = 16
) (
    input  logic [PA_W-1:0] base_a,
    input  logic [PA_W-1:0] base_b,
    output logic            overlap
);

    logic [PA_W-1:0] dist_ab;
    logic [PA_W-1:0] dist_ba;
    logic            near_ab;
    logic            near_ba;

    always_comb begin
        // Modular distances in both directions
        dist_ab = base_a - base_b;
        dist_ba = base_b - base_a;
        // Below one segment span when no bit at or above OFS_W is set
        near_ab = (dist_ab[PA_W-1:OFS_W] == '0);
        near_ba = (dist_ba[PA_W-1:OFS_W] == '0);
        overlap = near_ab | near_ba;
    end

endmodule

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int PA_W  = SEG_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_sel,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [1:0]       ovl_sel_a,
    input  logic [1:0]       ovl_sel_b,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_addr,
    output logic [PA_W-1:0]  rsp_base,
    output logic             ovl_flag
);

    localparam int CODE_SLOT = int'(SEG_CODE);

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] base;
        logic            ovl;
    } rsp_t;

    logic [NUM_SEGS-1:0][SEG_W-1:0] segs;
    logic [PA_W-1:0]                calc_base;
    logic [PA_W-1:0]                calc_addr;
    logic [PA_W-1:0]                cmp_base_a;
    logic [PA_W-1:0]                cmp_base_b;
    logic                           cmp_ovl;
    rsp_t                           st_d, st_q;

    seg_regfile #(
        .NSEG     (NUM_SEGS),
        .SEG_W    (SEG_W),
        .CODE_IDX (CODE_SLOT),
        .CODE_RST ({SEG_W{1'b1}})
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .segs    (segs)
    );

    seg_addr_calc #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT)
    ) calc_i (
        .seg  (segs[req_sel]),
        .ofs  (req_ofs),
        .base (calc_base),
        .addr (calc_addr)
    );

    always_comb begin
        cmp_base_a = {segs[ovl_sel_a], {SHIFT{1'b0}}};
        cmp_base_b = {segs[ovl_sel_b], {SHIFT{1'b0}}};
    end

    seg_overlap_cmp #(
        .PA_W  (PA_W),
        .OFS_W (OFS_W)
    ) cmp_i (
        .base_a  (cmp_base_a),
        .base_b  (cmp_base_b),
        .overlap (cmp_ovl)
    );

    // Next-state: a response is captured only for a request; otherwise held
    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        st_d.ovl   = cmp_ovl;
        if (req_valid) begin
            st_d.addr = calc_addr;
            st_d.base = calc_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_addr  = st_q.addr;
    assign rsp_base  = st_q.base;
    assign ovl_flag  = st_q.ovl;

endmodule

// File: rtl/seg_addr_chk.sv
`timescale 1ns/1ps
module seg_addr_chk #(
    parameter int SEG_W  = 16,
    parameter int OFS_W  = 16,
    parameter int SHIFT  = 4,
    localparam int PA_W  = SEG_W + SHIFT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [SEG_W-1:0] wr_data,
    input logic             req_valid,
    input logic [1:0]       req_sel,
    input logic [OFS_W-1:0] req_ofs,
    input logic [1:0]       ovl_sel_a,
    input logic [1:0]       ovl_sel_b,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_addr,
    input logic [PA_W-1:0]  rsp_base,
    input logic             ovl_flag
);

    localparam int EXT_W = PA_W - OFS_W;

    logic [PA_W-1:0] span;
    logic [PA_W-1:0] ofs_ext;

    always_comb begin
        span    = rsp_addr - rsp_base;
        ofs_ext = {{EXT_W{1'b0}}, req_ofs};
    end

    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));

    a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_base[SHIFT-1:0] == '0));

    a_r5_addr_is_sum: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr == rsp_base + $past(ofs_ext)));

    a_r5_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (span[PA_W-1:OFS_W] == '0));

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_addr) && $stable(rsp_base)));

    a_r9_same_seg_overlaps: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_sel_a == ovl_sel_b) |=> ovl_flag);

    a_r3_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && req_valid && (req_sel == $past(wr_sel)))
        |=> (rsp_base == {$past(wr_data, 2), {SHIFT{1'b0}}}));

endmodule

bind seg_addr_gen seg_addr_chk #(
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .SHIFT (SHIFT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .req_valid (req_valid),
    .req_sel   (req_sel),
    .req_ofs   (req_ofs),
    .ovl_sel_a (ovl_sel_a),
    .ovl_sel_b (ovl_sel_b),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_base  (rsp_base),
    .ovl_flag  (ovl_flag)
);

// File: tb/seg_addr_gen_tb_top.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = '0;
    logic [15:0] req_ofs = '0;
    logic [1:0]  ovl_sel_a = '0;
    logic [1:0]  ovl_sel_b = '0;
    logic        rsp_valid;
    logic [19:0] rsp_addr;
    logic [19:0] rsp_base;
    logic        ovl_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_sel(req_sel), .req_ofs(req_ofs),
        .ovl_sel_a(ovl_sel_a), .ovl_sel_b(ovl_sel_b),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_base(rsp_base), .ovl_flag(ovl_flag)
    );

    // Behavioural reference model (index = select code: 0 extra,1 code,2 stack,3 data)
    int unsigned m_seg [4] = '{0, 32'hFFFF, 0, 0};
    int unsigned m_addr = 0;
    int unsigned m_base = 0;
    bit          m_valid = 0;
    bit          m_ovl = 0;
    int unsigned ba, bb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seg   = '{0, 32'hFFFF, 0, 0};
            m_valid = 0; m_addr = 0; m_base = 0; m_ovl = 0;
        end else begin
            m_valid = req_valid;
            if (req_valid) begin
                m_base = m_seg[req_sel] * 16;
                m_addr = (m_base + req_ofs) % 32'h100000;
            end
            ba = m_seg[ovl_sel_a] * 16;
            bb = m_seg[ovl_sel_b] * 16;
            m_ovl = (((ba - bb) % 32'h100000) < 32'h10000) ||
                    (((bb - ba) % 32'h100000) < 32'h10000);
            if (wr_en) m_seg[wr_sel] = wr_data;
        end
    end

    task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R6 rsp_valid", 32'(rsp_valid), 32'(m_valid));
            chk("R5 rsp_addr",  32'(rsp_addr),  m_addr);
            chk("R4 rsp_base",  32'(rsp_base),  m_base);
            chk("R8 ovl_flag",  32'(ovl_flag),  32'(m_ovl));
        end
    end

    task automatic cyc(input bit we, input int ws, input int wd,
                       input bit rv, input int rs, input int ro,
                       input int oa, input int ob);
        wr_en = we; wr_sel = ws[1:0]; wr_data = wd[15:0];
        req_valid = rv; req_sel = rs[1:0]; req_ofs = ro[15:0];
        ovl_sel_a = oa[1:0]; ovl_sel_b = ob[1:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs zero under reset
        chk("R10 rsp_valid", 32'(rsp_valid), 0);
        chk("R10 rsp_addr",  32'(rsp_addr),  0);
        chk("R10 rsp_base",  32'(rsp_base),  0);
        chk("R10 ovl_flag",  32'(ovl_flag),  0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;

        // R1/R2: code resets to FFFFh, extra to 0; R9 same segment overlaps
        cyc(0, 0, 0, 1, 1, 0, 0, 0);
        chk("R1 code reset addr", 32'(rsp_addr), 32'hFFFF0);
        chk("R9 extra vs extra",  32'(ovl_flag), 1);
        cyc(0, 0, 0, 1, 0, 'h0123, 1, 3);
        chk("R1 extra reset addr", 32'(rsp_addr), 32'h00123);
        chk("R8 wrap overlap code/data", 32'(ovl_flag), 1);

        // R2/R3: load each register by its code
        cyc(1, 1, 'h0009, 0, 0, 0, 0, 0);
        cyc(1, 3, 'h0FFF, 0, 0, 0, 0, 0);
        cyc(1, 2, 'h10E0, 0, 0, 0, 0, 0);
        cyc(1, 0, 'h3281, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 2, 'h0010, 1, 3);
        chk("R2 stack addr", 32'(rsp_addr), 32'h10E10);
        chk("R8 code/data overlap", 32'(ovl_flag), 1);
        cyc(0, 0, 0, 1, 3, 0, 2, 0);
        chk("R2 data base", 32'(rsp_base), 32'h0FFF0);
        chk("R8 stack/extra disjoint", 32'(ovl_flag), 0);
        cyc(0, 0, 0, 1, 0, 'h0004, 1, 2);
        chk("R2 extra addr", 32'(rsp_addr), 32'h32814);
        chk("R8 code/stack disjoint", 32'(ovl_flag), 0);

        // R3: same-cycle write is not seen by the request
        cyc(1, 3, 'hFFFF, 1, 3, 'hFFFF, 0, 1);
        chk("R3 old value same cycle", 32'(rsp_addr), 32'h1FFEF);
        // R5: new value next cycle, sum wraps past FFFFFh
        cyc(0, 0, 0, 1, 3, 'hFFFF, 0, 1);
        chk("R3 new base", 32'(rsp_base), 32'hFFFF0);
        chk("R5 wrap addr", 32'(rsp_addr), 32'h0FFEF);

        // R6/R7: idle cycles hold the response
        cyc(0, 0, 0, 0, 1, 'h5555, 0, 1);
        chk("R6 no request", 32'(rsp_valid), 0);
        chk("R7 addr held", 32'(rsp_addr), 32'h0FFEF);
        cyc(1, 3, 'h0001, 0, 2, 'hAAAA, 0, 1);
        chk("R7 addr held after write", 32'(rsp_addr), 32'h0FFEF);
        chk("R7 base held after write", 32'(rsp_base), 32'hFFFF0);

        // R8: overlap only across the top of memory
        cyc(1, 0, 'hF800, 0, 0, 0, 0, 0);
        cyc(1, 1, 'h0040, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 overlap across wrap", 32'(ovl_flag), 1);
        cyc(0, 0, 0, 0, 0, 0, 1, 2);
        chk("R8 code/stack apart", 32'(ovl_flag), 0);
        cyc(0, 0, 0, 0, 0, 0, 3, 3);
        chk("R9 data vs data", 32'(ovl_flag), 1);

        // Mixed traffic checked by the per-cycle model comparison
        for (int i = 0; i < 4000; i++) begin
            cyc(bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 16'hFFFF)),
                bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 16'hFFFF)),
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
        end

        cmp_on = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule